// File: doc/BRIEF.md
# Halfword pack-with-shift unit

A one-stage datapath unit that builds a 32-bit word from two halves taken from two operands. In one mode the low half of the first operand is kept. The upper half is filled from the second operand after a logical left shift. In the other mode the high half of the first operand is kept. The lower half is filled from the second operand after an arithmetic right shift. A 5-bit shift field sets the distance. Its zero code means something different in each mode.

The issuing pipeline presents both operands, the mode, the shift field and a valid strobe. One clock later the merged word appears on the output with its own valid flag. The unit drives no condition flags. If the pipeline marks the destination as illegal (stack pointer or program counter), the result is withheld and a one-cycle error strobe is raised instead.

Top module: `halfword_pack_unit`

## Requirements
- R1: With `op_i` = 0 (bottom-top mode), `result_o[15:0]` equals `a_i[15:0]` from the issuing cycle.
- R2: With `op_i` = 0, `result_o[31:16]` equals bits [31:16] of `b_i` shifted left logically by `shamt_i` (0 to 31); a field of 0 leaves `b_i` unshifted.
- R3: With `op_i` = 1 (top-bottom mode), `result_o[31:16]` equals `a_i[31:16]` from the issuing cycle.
- R4: With `op_i` = 1, `result_o[15:0]` equals bits [15:0] of `b_i` shifted right arithmetically by `shamt_i` for fields 1 to 31; a field of 1 gives `b_i[16:1]`.
- R5: With `op_i` = 1 and `shamt_i` = 0, the shift distance is 32, so `result_o[15:0]` is sixteen copies of `b_i[31]` (16'hFFFF or 16'h0000).
- R6: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high and `bad_dst_i` low; it is low otherwise.
- R7: When `valid_i` and `bad_dst_i` are both high, the next cycle has `err_o` high for one cycle and `valid_o` low, and `result_o` keeps its previous value.
- R8: `result_o` changes only after an accepted operation; in idle cycles it holds its value.
- R9: While `rst_ni` is low, `valid_o`, `err_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request strobe |
| op_i | input | 1 | Mode: 0 bottom-top with left shift, 1 top-bottom with arithmetic right shift |
| a_i | input | 32 | First operand, source of the kept half |
| b_i | input | 32 | Second operand, source of the shifted half |
| shamt_i | input | 5 | Shift field |
| bad_dst_i | input | 1 | Destination is stack pointer or program counter |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 32 | Packed result |
| err_o | output | 1 | One-cycle strobe for a rejected request |

## Verification
The hardest situation to reach is the top-bottom zero field. There the 5-bit code has to become a distance of 32, and every bit of the low half must come from the sign of `b_i`. A bench that only sweeps ordinary shifts never gets there. The directed sweep therefore covers every field value from 0 to 31 in both modes, using second operands with the sign bit both set and clear. The check on the error path first loads a known result and then issues a rejected request, so that a result that changed by mistake can be seen at the port.

// File: rtl/hpack_pkg.sv
package hpack_pkg;
  typedef enum logic {
    PACK_BT = 1'b0,  // keep low half of a, shifted-left b on top
    PACK_TB = 1'b1   // keep high half of a, arith-right b on bottom
  } pack_op_e;
endpackage

// File: rtl/hpack_shift_decode.sv
module hpack_shift_decode
  import hpack_pkg::*;
#(
  parameter int unsigned FIELD_W = 5,
  localparam int unsigned AMT_W  = FIELD_W + 1
) (
  input  pack_op_e           op_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [AMT_W-1:0]   amt_o
);
  // right-shift mode: zero field encodes full-width distance
  always_comb begin
    if (op_i == PACK_TB && field_i == '0) amt_o = AMT_W'(1) << FIELD_W;
    else                                  amt_o = {1'b0, field_i};
  end
endmodule

// File: rtl/hpack_half_merge.sv
module hpack_half_merge
  import hpack_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 6,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  pack_op_e            op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [AMT_W-1:0]    amt_i,
  output logic [DATA_W-1:0]   res_o
);
  logic [DATA_W-1:0] shl, sar;

  assign shl = b_i << amt_i;
  assign sar = DATA_W'($signed(b_i) >>> amt_i);

  always_comb begin
    unique case (op_i)
      PACK_BT: res_o = {shl[DATA_W-1:HALF_W], a_i[HALF_W-1:0]};
      PACK_TB: res_o = {a_i[DATA_W-1:HALF_W], sar[HALF_W-1:0]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/halfword_pack_unit.sv
module halfword_pack_unit
  import hpack_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FIELD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [31:0]       a_i,
  input  logic [31:0]       b_i,
  input  logic [4:0]        shamt_i,
  input  logic              bad_dst_i,
  output logic              valid_o,
  output logic [31:0]       result_o,
  output logic              err_o
);
  localparam int unsigned AMT_W = FIELD_W + 1;

  pack_op_e          op;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] merged;
  logic              accept;

  assign op     = pack_op_e'(op_i);
  assign accept = valid_i & ~bad_dst_i;

  hpack_shift_decode #(.FIELD_W(FIELD_W)) u_dec (
    .op_i    (op),
    .field_i (shamt_i),
    .amt_o   (amt)
  );

  hpack_half_merge #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_merge (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .amt_i (amt),
    .res_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= accept;
      err_o   <= valid_i & bad_dst_i;
      if (accept) result_o <= merged;
    end
  end
endmodule

// File: rtl/hpack_checker.sv
module hpack_checker #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [4:0]        shamt_i,
  input logic              bad_dst_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              err_o
);
  logic unused_b0;
  assign unused_b0 = b_i[0];

  assert_bt_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i && !op_i) |=> result_o[HALF_W-1:0] == $past(a_i[HALF_W-1:0]));

  assert_bt_noshift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i && !op_i && shamt_i == 5'd0)
      |=> result_o[DATA_W-1:HALF_W] == $past(b_i[DATA_W-1:HALF_W]));

  assert_tb_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i && op_i) |=> result_o[DATA_W-1:HALF_W] == $past(a_i[DATA_W-1:HALF_W]));

  assert_tb_shift1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i && op_i && shamt_i == 5'd1)
      |=> result_o[HALF_W-1:0] == $past(b_i[HALF_W:1]));

  assert_tb_signfill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i && op_i && shamt_i == 5'd0)
      |=> result_o[HALF_W-1:0] == {HALF_W{$past(b_i[DATA_W-1])}});

  assert_valid_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_dst_i) |=> valid_o);

  assert_valid_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !bad_dst_i) |=> !valid_o);

  assert_err_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bad_dst_i) |=> (err_o && !valid_o));

  assert_err_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && bad_dst_i) |=> !err_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !bad_dst_i) |=> $stable(result_o));

  always_comb begin
    if (!rst_ni) assert_reset_R9: assert (!valid_o && !err_o && result_o == '0);
  end
endmodule

bind halfword_pack_unit hpack_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_halfword_pack_unit.sv
module tb_halfword_pack_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        bad_dst_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  halfword_pack_unit dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .shamt_i, .bad_dst_i,
    .valid_o, .result_o, .err_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] expect_word(logic op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    logic [63:0] wide;
    logic [15:0] lo;
    if (!op) begin
      wide = {32'd0, b} << sh;
      return {wide[31:16], a[15:0]};
    end
    if (sh == 5'd0) lo = {16{b[31]}};
    else begin
      wide = {{32{b[31]}}, b} >> sh;
      lo = wide[15:0];
    end
    return {a[31:16], lo};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic op, logic [31:0] a, logic [31:0] b, logic [4:0] sh, logic bad);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; shamt_i = sh; bad_dst_i = bad;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; bad_dst_i = 1'b0;
  endtask

  task automatic test_reset();
    #(CLK_PERIOD*2);
    check("R9 valid", {31'd0, valid_o}, 32'd0);
    check("R9 err", {31'd0, err_o}, 32'd0);
    check("R9 result", result_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic test_sweep(logic op, logic [31:0] a, logic [31:0] b);
    for (int s = 0; s < 32; s++) begin
      issue(op, a, b, 5'(s), 1'b0);
      if (!op) check($sformatf("R1/R2 bt shift %0d", s), result_o, expect_word(op, a, b, 5'(s)));
      else if (s == 0) check("R5 tb zero field", result_o, expect_word(op, a, b, 5'(s)));
      else check($sformatf("R3/R4 tb shift %0d", s), result_o, expect_word(op, a, b, 5'(s)));
    end
  endtask

  task automatic test_corners();
    issue(1'b1, 32'hABCD_1234, 32'h0001_8003, 5'd1, 1'b0);
    check("R4 shift one", result_o, {16'hABCD, 16'hC001});
    issue(1'b1, 32'h1111_2222, 32'h8000_0000, 5'd0, 1'b0);
    check("R5 fill ones", result_o, 32'h1111_FFFF);
    issue(1'b1, 32'h1111_2222, 32'h7FFF_FFFF, 5'd0, 1'b0);
    check("R5 fill zeros", result_o, 32'h1111_0000);
    issue(1'b0, 32'h5555_6666, 32'h1234_ABCD, 5'd0, 1'b0);
    check("R2 no shift", result_o, 32'h1234_6666);
  endtask

  task automatic test_latency();
    issue(1'b0, 32'h0000_00AA, 32'h0000_0001, 5'd16, 1'b0);
    check("R6 valid after request", {31'd0, valid_o}, 32'd1);
    check("R2 shift 16", result_o, 32'h0001_00AA);
    @(posedge clk_i); #1;
    check("R6 valid drops", {31'd0, valid_o}, 32'd0);
    check("R8 hold idle", result_o, 32'h0001_00AA);
  endtask

  task automatic test_bad_dst();
    issue(1'b1, 32'hCAFE_0000, 32'h0000_4321, 5'd4, 1'b0);
    check("R4 before reject", result_o, 32'hCAFE_0432);
    issue(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 1'b1);
    check("R7 err high", {31'd0, err_o}, 32'd1);
    check("R7 valid low", {31'd0, valid_o}, 32'd0);
    check("R7 result held", result_o, 32'hCAFE_0432);
    @(posedge clk_i); #1;
    check("R7 err one cycle", {31'd0, err_o}, 32'd0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [4:0]  sh = 5'($urandom);
      logic        op = 1'($urandom);
      issue(op, a, b, sh, 1'b0);
      check(op ? "R3/R4/R5 random" : "R1/R2 random", result_o, expect_word(op, a, b, sh));
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_sweep(1'b0, 32'h9876_5432, 32'h8421_C3A5);
    test_sweep(1'b1, 32'h9876_5432, 32'h8421_C3A5);
    test_sweep(1'b1, 32'h0F0F_F0F0, 32'h7B3D_9E61);
    test_corners();
    test_latency();
    test_bad_dst();
    test_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule